// File: doc/BRIEF.md
# Clock Output Power-Down Controller

This block sits between the divider outputs of a clock generator and its output pads. It takes an asynchronous power-down request and stops every output clock cleanly. Single-ended clocks park low. Each differential pair parks with its true pin high, and a per-pair mode bit decides whether the complement pin alone is released or both pins are released to high impedance. Stopping and restarting never cut a pulse short.

When the request is withdrawn, every pair is driven to a defined level at once: true high and complement low. The block then waits for the PLL-lock input before clocks resume, and each output restarts at its own next low phase. All logic runs on a fast master clock. The clock sources arrive as levels that change in step with that clock, and every pad-facing signal comes from a register, so no output can glitch.

A small write port loads the per-pair mode bits, and a read port returns them.

Top module: `clkout_pd_ctrl`

## Requirements
- R1: The request and the lock input each pass through a two-flop synchroniser. Power-down is accepted only when the synchronised request is seen high at two consecutive rising edges of the complement clock of reference pair 0. A request that is seen at one such edge only is ignored, and the outputs keep toggling.
- R2: Once power-down is accepted, each single-ended output is held low from the next low phase of its source. Every high pulse on a single-ended output has the full length of the source's high phase.
- R3: Each differential pair stops at the next low phase of its complement source, with its true output held at 1. Every low pulse on a true output has the full length of the source's low phase. A true output is never released while its complement is driven.
- R4: With mode bit 0 for a pair, power-down drives that pair's true output high (true_oe=1) and releases its complement (comp_oe=0).
- R5: With mode bit 1 for a pair, power-down releases both pins of that pair (true_oe=0, comp_oe=0).
- R6: Bit j of `cfg_wdata_i` is the mode bit of pair j. It is written on a clock edge where `cfg_we_i` is 1 and read on `cfg_rdata_o`. The bits reset to 0, and without a write they do not change.
- R7: No later than five clock cycles after the request drops, every pair is driven with true=1, complement=0 and both enables at 1, and single-ended outputs are 0. This holds, with no toggling, for as long as lock stays low.
- R8: After the synchronised lock is high and the request is low, outputs restart. In steady running, each output equals its source as sampled at the last clock edge, and all enables are 1.
- R9: After reset, every output is in the driven stopped state of R7 until lock is seen.
- R10: All outputs are stopped no more than 30 master-clock cycles after the request rises, with the default source periods (half periods of 2 to 4 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Asynchronous power-down request |
| pll_lock_i | input | 1 | Asynchronous PLL-lock indication |
| cfg_we_i | input | 1 | Mode-bit write strobe |
| cfg_wdata_i | input | N_DIFF | Mode bits to write, one per pair |
| cfg_rdata_o | output | N_DIFF | Current mode bits |
| se_i | input | N_SE | Single-ended source clock levels |
| diff_t_i | input | N_DIFF | Differential true source levels |
| diff_c_i | input | N_DIFF | Differential complement source levels |
| se_o | output | N_SE | Gated single-ended clocks |
| diff_t_o | output | N_DIFF | Gated true outputs |
| diff_c_o | output | N_DIFF | Gated complement outputs |
| diff_t_oe_o | output | N_DIFF | True-pin output enable (0 = high impedance) |
| diff_c_oe_o | output | N_DIFF | Complement-pin output enable (0 = high impedance) |

## Verification
The assertions assume that the source levels change only between master-clock edges and that each differential complement is the inverse of its true level. The bench generates every source from one tick counter on the falling master edge, with complement = ~true, so both assumptions always hold. The bench also changes the mode bits only while clocks are running, and it drops lock before it releases the request. This keeps the parked state and the pre-lock driven state separately visible at the ports.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;
  typedef enum logic [1:0] {
    ST_LOCKWAIT = 2'd0,
    ST_RUN      = 2'd1,
    ST_DOWN     = 2'd2
  } pd_state_e;
endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/clkpd_ctrl.sv
module clkpd_ctrl
  import clkpd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic lock_s_i,
  input  logic ref_c_i,
  output logic run_o,
  output logic down_o
);
  pd_state_e state_q, state_d;
  logic ref_prev_q, hit_q;
  logic ref_rise, accept;

  assign ref_rise = ref_c_i & ~ref_prev_q;
  // second consecutive reference edge with request still high
  assign accept   = ref_rise & req_s_i & hit_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_LOCKWAIT: begin
        if (accept)                   state_d = ST_DOWN;
        else if (lock_s_i && !req_s_i) state_d = ST_RUN;
      end
      ST_RUN:  if (accept)   state_d = ST_DOWN;
      ST_DOWN: if (!req_s_i) state_d = ST_LOCKWAIT;
      default: state_d = ST_LOCKWAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_LOCKWAIT;
      ref_prev_q <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      ref_prev_q <= ref_c_i;
      if (state_q == ST_DOWN) hit_q <= 1'b0;
      else if (ref_rise)      hit_q <= req_s_i;
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign down_o = (state_q == ST_DOWN);
endmodule

// File: rtl/clkpd_se_gate.sv
module clkpd_se_gate #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         run_i,
  output logic [N-1:0] out_o
);
  for (genvar k = 0; k < N; k++) begin : g_ch
    logic en_q, out_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q  <= 1'b0;
        out_q <= 1'b0;
      end else begin
        // enable moves only in the source's low phase
        if (!src_i[k]) en_q <= run_i;
        out_q <= src_i[k] & en_q;
      end
    end
    assign out_o[k] = out_q;
  end
endmodule

// File: rtl/clkpd_diff_gate.sv
module clkpd_diff_gate #(
  parameter int N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] t_i,
  input  logic [N-1:0] c_i,
  input  logic         run_i,
  input  logic         down_i,
  input  logic [N-1:0] mode_i,
  output logic [N-1:0] t_o,
  output logic [N-1:0] c_o,
  output logic [N-1:0] oe_t_o,
  output logic [N-1:0] oe_c_o
);
  for (genvar j = 0; j < N; j++) begin : g_pair
    logic en_q, t_q, c_q, oe_t_q, oe_c_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        t_q    <= 1'b1;
        c_q    <= 1'b0;
        oe_t_q <= 1'b1;
        oe_c_q <= 1'b1;
      end else begin
        // switch only while complement is low, true pin is then high
        if (!c_i[j]) en_q <= run_i;
        t_q    <= en_q ? t_i[j] : 1'b1;
        c_q    <= en_q ? c_i[j] : 1'b0;
        oe_t_q <= en_q | ~(down_i & mode_i[j]);
        oe_c_q <= en_q | ~down_i;
      end
    end
    assign t_o[j]    = t_q;
    assign c_o[j]    = c_q;
    assign oe_t_o[j] = oe_t_q;
    assign oe_c_o[j] = oe_c_q;
  end
endmodule

// File: rtl/clkout_pd_ctrl.sv
module clkout_pd_ctrl #(
  parameter int N_SE     = 3,
  parameter int N_DIFF   = 2,
  parameter int REF_PAIR = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_req_i,
  input  logic              pll_lock_i,
  input  logic              cfg_we_i,
  input  logic [N_DIFF-1:0] cfg_wdata_i,
  output logic [N_DIFF-1:0] cfg_rdata_o,
  input  logic [N_SE-1:0]   se_i,
  input  logic [N_DIFF-1:0] diff_t_i,
  input  logic [N_DIFF-1:0] diff_c_i,
  output logic [N_SE-1:0]   se_o,
  output logic [N_DIFF-1:0] diff_t_o,
  output logic [N_DIFF-1:0] diff_c_o,
  output logic [N_DIFF-1:0] diff_t_oe_o,
  output logic [N_DIFF-1:0] diff_c_oe_o
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] async_in, sync_out;
  logic run, down;
  logic [N_DIFF-1:0] mode_q;

  assign async_in = {pll_lock_i, pd_req_i};

  clkpd_sync #(.W(SYNC_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_in),
    .q_o   (sync_out)
  );

  clkpd_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_s_i (sync_out[0]),
    .lock_s_i(sync_out[1]),
    .ref_c_i (diff_c_i[REF_PAIR]),
    .run_o   (run),
    .down_o  (down)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= '0;
    else if (cfg_we_i) mode_q <= cfg_wdata_i;
  end
  assign cfg_rdata_o = mode_q;

  clkpd_se_gate #(.N(N_SE)) u_se (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (se_i),
    .run_i (run),
    .out_o (se_o)
  );

  clkpd_diff_gate #(.N(N_DIFF)) u_diff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .t_i   (diff_t_i),
    .c_i   (diff_c_i),
    .run_i (run),
    .down_i(down),
    .mode_i(mode_q),
    .t_o   (diff_t_o),
    .c_o   (diff_c_o),
    .oe_t_o(diff_t_oe_o),
    .oe_c_o(diff_c_oe_o)
  );
endmodule

// File: rtl/clkout_pd_ctrl_chk.sv
module clkout_pd_ctrl_chk #(
  parameter int N_SE   = 3,
  parameter int N_DIFF = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [N_DIFF-1:0] cfg_rdata_o,
  input logic [N_SE-1:0]   se_i,
  input logic [N_DIFF-1:0] diff_t_i,
  input logic [N_DIFF-1:0] diff_c_i,
  input logic [N_SE-1:0]   se_o,
  input logic [N_DIFF-1:0] diff_t_o,
  input logic [N_DIFF-1:0] diff_c_o,
  input logic [N_DIFF-1:0] diff_t_oe_o,
  input logic [N_DIFF-1:0] diff_c_oe_o
);
  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cfg_we_i) |-> $stable(cfg_rdata_o));

  for (genvar k = 0; k < N_SE; k++) begin : g_se
    // R2
    se_high_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      se_o[k] |-> $past(se_i[k]));
  end

  for (genvar j = 0; j < N_DIFF; j++) begin : g_pair
    // R3
    t_low_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !diff_t_o[j] |-> !$past(diff_t_i[j]));
    // R3
    tri_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !diff_t_oe_o[j] |-> !diff_c_oe_o[j]);
    // R8
    c_high_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      diff_c_o[j] |-> $past(diff_c_i[j]));
    // R4
    mode0_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!diff_c_oe_o[j] && !$past(cfg_rdata_o[j])) |-> (diff_t_oe_o[j] && diff_t_o[j]));
    // R5
    mode1_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!diff_c_oe_o[j] && $past(cfg_rdata_o[j])) |-> !diff_t_oe_o[j]);
  end
endmodule

bind clkout_pd_ctrl clkout_pd_ctrl_chk #(.N_SE(N_SE), .N_DIFF(N_DIFF)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_rdata_o(cfg_rdata_o),
  .se_i       (se_i),
  .diff_t_i   (diff_t_i),
  .diff_c_i   (diff_c_i),
  .se_o       (se_o),
  .diff_t_o   (diff_t_o),
  .diff_c_o   (diff_c_o),
  .diff_t_oe_o(diff_t_oe_o),
  .diff_c_oe_o(diff_c_oe_o)
);

// File: tb/tb_clkout_pd_ctrl.sv
module tb_clkout_pd_ctrl;
  localparam int N_SE = 3;
  localparam int N_DIFF = 2;

  logic clk = 1'b0, rst_ni = 1'b0, pd_req = 1'b0, lock = 1'b0, cfg_we = 1'b0;
  logic [N_DIFF-1:0] cfg_wdata = '0, cfg_rdata;
  logic [N_SE-1:0] se_i = '0, se_o;
  logic [N_DIFF-1:0] t_i = '0, c_i = '1, t_o, c_o, oe_t, oe_c;

  int checks = 0, errors = 0, tick = 0;
  bit steady = 0, done = 0;

  always #5 clk = ~clk;

  clkout_pd_ctrl #(.N_SE(N_SE), .N_DIFF(N_DIFF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pd_req_i(pd_req), .pll_lock_i(lock),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .se_i(se_i), .diff_t_i(t_i), .diff_c_i(c_i),
    .se_o(se_o), .diff_t_o(t_o), .diff_c_o(c_o),
    .diff_t_oe_o(oe_t), .diff_c_oe_o(oe_c)
  );

  function automatic int half_of(int idx);
    return idx + 2;
  endfunction

  function automatic logic [3:0] parked(logic m);  // {oe_t, t, oe_c, c}
    return m ? 4'b0000 : 4'b1100;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  // sources: all change on the falling edge, complement = ~true
  initial forever begin
    @(negedge clk);
    tick++;
    for (int k = 0; k < N_SE; k++) se_i[k] = (tick % (2*half_of(k))) < half_of(k);
    for (int j = 0; j < N_DIFF; j++) begin
      t_i[j] = (tick % (2*half_of(j))) < half_of(j);
      c_i[j] = ~t_i[j];
    end
  end

  // pulse-length and steady-run monitor
  int se_run[N_SE];
  int t_run[N_DIFF];
  initial begin
    for (int k = 0; k < N_SE; k++) se_run[k] = 0;
    for (int j = 0; j < N_DIFF; j++) t_run[j] = 0;
    forever begin
      @(posedge clk); #2;
      if (rst_ni) begin
        for (int k = 0; k < N_SE; k++) begin
          if (se_o[k]) se_run[k]++;
          else if (se_run[k] > 0) begin
            chk(se_run[k] == half_of(k), "R2", "se high pulse length", se_run[k], half_of(k));
            se_run[k] = 0;
          end
        end
        for (int j = 0; j < N_DIFF; j++) begin
          if (!t_o[j]) t_run[j]++;
          else if (t_run[j] > 0) begin
            chk(t_run[j] == half_of(j), "R3", "true low pulse length", t_run[j], half_of(j));
            t_run[j] = 0;
          end
        end
        if (steady) begin
          chk(se_o == se_i, "R8", "se follows source", se_o, se_i);
          chk({t_o, c_o} == {t_i, c_i}, "R8", "pair follows source", {t_o, c_o}, {t_i, c_i});
          chk((oe_t & oe_c) == '1, "R8", "enables on", {oe_t, oe_c}, '1);
        end
      end
    end
  end

  task automatic check_driven_idle(string req);
    chk(se_o == '0, req, "se low", se_o, 0);
    chk(t_o == '1 && c_o == '0, req, "pair t=1 c=0", {t_o, c_o}, {{N_DIFF{1'b1}}, {N_DIFF{1'b0}}});
    chk(oe_t == '1 && oe_c == '1, req, "pair driven", {oe_t, oe_c}, '1);
  endtask

  task automatic check_parked(logic [N_DIFF-1:0] m);
    chk(se_o == '0, "R2", "se parked low", se_o, 0);
    for (int j = 0; j < N_DIFF; j++) begin
      logic [3:0] exp, act;
      exp = parked(m[j]);
      act = {oe_t[j], oe_t[j] ? t_o[j] : 1'b0, oe_c[j], c_o[j]};
      chk(act == exp, m[j] ? "R5" : "R4", "parked pair state", act, exp);
    end
  endtask

  task automatic write_mode(logic [N_DIFF-1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = m;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = ~m;
    cyc(1);
    chk(cfg_rdata == m, "R6", "mode readback", cfg_rdata, m);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N_DIFF-1:0] mode;
    logic [4*N_DIFF+N_SE-1:0] snap;
    void'($urandom(32'd1234));
    cyc(3);
    @(negedge clk) rst_ni = 1'b1;
    cyc(2);
    // R9 reset state
    check_driven_idle("R9");
    chk(cfg_rdata == '0, "R6", "mode reset", cfg_rdata, 0);
    cyc(20);
    check_driven_idle("R9");

    @(negedge clk) lock = 1'b1;
    cyc(25);
    steady = 1;
    cyc(30);

    // R1 one-cycle request is ignored
    @(negedge clk) pd_req = 1'b1;
    @(negedge clk) pd_req = 1'b0;
    cyc(30);
    chk(steady && oe_c == '1, "R1", "short request ignored", oe_c, '1);

    // R6 strobe low keeps value
    write_mode(2'b10);
    @(negedge clk) cfg_wdata = 2'b01;
    cyc(2);
    chk(cfg_rdata == 2'b10, "R6", "no write without strobe", cfg_rdata, 2'b10);

    for (int it = 0; it < 10; it++) begin
      mode = (it < 4) ? N_DIFF'(it) : N_DIFF'($urandom_range(0, 3));
      write_mode(mode);
      if ($urandom_range(0, 1) == 1) begin
        @(negedge clk) pd_req = 1'b1;   // R1 short pulse inside run
        @(negedge clk) pd_req = 1'b0;
      end
      cyc($urandom_range(20, 60));
      @(negedge clk);
      steady = 0;
      pd_req = 1'b1;
      cyc(8);
      @(negedge clk) lock = 1'b0;
      cyc(22);
      // R10 stopped within 30 cycles of the request
      check_parked(mode);
      snap = {se_o, t_o, c_o, oe_t, oe_c};
      cyc($urandom_range(5, 20));
      chk({se_o, t_o, c_o, oe_t, oe_c} == snap, "R10", "parked state holds", {se_o, t_o, c_o, oe_t, oe_c}, snap);
      @(negedge clk) pd_req = 1'b0;
      cyc(5);
      check_driven_idle("R7");
      cyc($urandom_range(1, 15));
      check_driven_idle("R7");
      @(negedge clk) lock = 1'b1;
      cyc(25);
      steady = 1;
      cyc(10);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule